// File: doc/BRIEF.md
# Cache Line Refill Memory Timing Controller

This block serves one cache miss at a time. It fetches a line of `WORDS` words from a slow main memory model and hands the words back to the cache one per strobe. The line's latency depends on a static organization select. The organization can be plain one-word-wide access, where every word pays a full fresh access. It can be fast page mode, where the row opens once and later columns come back quickly. It can be word interleaving across `WORDS` banks that all start together, with their words returned serially afterwards.

The main memory is an internal register array split into banks by the low word-address bits. The cache presents a line number with a single-cycle miss request while the controller is idle. It then watches the busy flag and receives each word together with a valid strobe and its word index. When the refill ends, a penalty register holds the total cycle count of that refill. The cycle in which the request is presented counts as cycle 1 of the refill.

Top module: `refill_line_ctrl`

## Requirements
- R1: After reset, busy and word_valid are low and penalty reads 0.
- R2: A miss_req seen while idle is accepted at that clock edge. Busy is high from the next cycle through the cycle of the last word strobe, and low in the cycle after it.
- R3: Words come back with indices 0, 1, .. WORDS-1 in ascending order. Word i carries the content of word address A = line*WORDS + i, which is {16'hCA00 + A, 16'h0F0F ^ A} for a 16-bit A.
- R4: With org code 0 (sequential), word i is strobed in cycle 27 + 25*i of the refill. A 4-word line therefore takes 102 cycles. Code 3 behaves exactly like code 0.
- R5: With org code 1 (page mode), word i is strobed in cycle 27 + 8*i, so a 4-word line takes 51 cycles.
- R6: With org code 2 (interleaved), word i is strobed in cycle 27 + i. The strobes fall in consecutive cycles, and a 4-word line takes 30 cycles.
- R7: With WORDS = 1 in sequential mode, the single word is strobed in cycle 27, and the penalty is 27.
- R8: In the cycle after the last strobe, penalty equals the cycle number of that last strobe. It then holds until the next refill ends.
- R9: A miss_req that arrives while busy is ignored. It does not change the line being fetched, the timing, or the penalty.
- R10: The org input is sampled only when a miss is accepted. Changing it during a refill has no effect on that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Miss request, taken while idle |
| miss_line | input | LINE_W | Line number of the missing line |
| org | input | 2 | Memory organization: 0 sequential, 1 page, 2 interleaved, 3 as 0 |
| busy | output | 1 | Refill in progress |
| word_valid | output | 1 | Returned word strobe |
| word_idx | output | IDX_W | Index of the returned word within the line |
| word_data | output | DATA_W | Returned word |
| penalty | output | CNT_W | Total cycles of the last completed refill |

## Verification
Several properties are checked by the assertions on every cycle. The latched organization and line stay steady while busy. Busy falls right after the last strobe. The penalty loaded at the end of a refill matches the organization's formula. Interleaved strobes come back to back, and the cycle counter never passes the longest possible penalty. The bench scenarios are needed for the rest: the exact strobe cycle of every word, the data returned for each word address, the reserved code behaving as sequential, the single-word line, and requests or org changes during a refill having no visible effect.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ORG_SEQ  = 2'd0,
    ORG_PAGE = 2'd1,
    ORG_BANK = 2'd2,
    ORG_RSVD = 2'd3
  } org_e;

  // cycles between successive word strobes for an organization
  function automatic int unsigned org_step(org_e o, int unsigned fresh,
                                           int unsigned col);
    case (o)
      ORG_PAGE: return col;
      ORG_BANK: return 1;
      default:  return fresh;
    endcase
  endfunction

  // refill cycle (request cycle = 1) in which word idx is strobed
  function automatic int unsigned ret_cycle(org_e o, int unsigned idx,
                                            int unsigned fresh,
                                            int unsigned col);
    return 2 + fresh + idx * org_step(o, fresh, col);
  endfunction

  // initial content of main-memory word address a
  function automatic logic [31:0] cell_init(int unsigned a);
    logic [15:0] a16;
    a16 = a[15:0];
    return {16'hCA00 + a16, 16'h0F0F ^ a16};
  endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank
  import refill_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ROWS    = 16,
  parameter int WORDS   = 4,
  parameter int BANK_ID = 0,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  row_sel,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [ROWS];

  // storage model: loaded with its pattern at reset, read only afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        cells[r] <= DATA_W'(cell_init(r * WORDS + BANK_ID));
    end
  end

  assign rd_data = cells[row_sel];

endmodule

// File: rtl/refill_timer.sv
module refill_timer
  import refill_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int FRESH = 25,
  parameter int COL   = 8,
  parameter int CNT_W = 7,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  org_e             org_in,
  output logic             busy,
  output org_e             org_held,
  output logic [CNT_W-1:0] cyc,
  output logic [IDX_W-1:0] widx,
  output logic             strobe,
  output logic             last
);

  localparam int MAX_PEN = 2 + FRESH * WORDS;

  logic             active;
  org_e             org_q;
  logic [CNT_W-1:0] cyc_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] due_cyc;

  always_comb begin
    due_cyc = CNT_W'(ret_cycle(org_q, 32'(idx_q), FRESH, COL));
    strobe  = active && (cyc_q == due_cyc);
    last    = strobe && (32'(idx_q) == WORDS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      org_q  <= ORG_SEQ;
      cyc_q  <= '0;
      idx_q  <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        org_q  <= org_in;
        cyc_q  <= CNT_W'(2);
        idx_q  <= '0;
      end
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (last)        active <= 1'b0;
      else if (strobe) idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy     = active;
  assign org_held = org_q;
  assign cyc      = cyc_q;
  assign widx     = idx_q;

  AST_ORG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(org_q)); // R10

  AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !active); // R2

  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (32'(cyc_q) <= MAX_PEN)); // R8

  AST_BANK_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !last && org_q == ORG_BANK) |=> strobe); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !last) |=> (idx_q == $past(idx_q) + 1'b1)); // R3

endmodule

// File: rtl/refill_line_ctrl.sv
module refill_line_ctrl
  import refill_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WORDS     = 4,
  parameter int MEM_LINES = 16,
  parameter int FRESH     = 25,
  parameter int COL       = 8,
  localparam int LINE_W   = (MEM_LINES > 1) ? $clog2(MEM_LINES) : 1,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W    = $clog2(2 + FRESH * WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_req,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [1:0]        org,
  output logic              busy,
  output logic              word_valid,
  output logic [IDX_W-1:0]  word_idx,
  output logic [DATA_W-1:0] word_data,
  output logic [CNT_W-1:0]  penalty
);

  logic              accept;
  logic              t_busy;
  org_e              t_org;
  logic [CNT_W-1:0]  t_cyc;
  logic [IDX_W-1:0]  t_idx;
  logic              t_strobe;
  logic              t_last;
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  pen_q;
  logic [DATA_W-1:0] bank_rd [WORDS];

  assign accept = miss_req && !t_busy;

  refill_timer #(
    .WORDS(WORDS), .FRESH(FRESH), .COL(COL), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .org_in  (org_e'(org)),
    .busy    (t_busy),
    .org_held(t_org),
    .cyc     (t_cyc),
    .widx    (t_idx),
    .strobe  (t_strobe),
    .last    (t_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      pen_q  <= '0;
    end else begin
      if (accept) line_q <= miss_line;
      if (t_last) pen_q  <= t_cyc;
    end
  end

  // one bank per word position: word address low bits pick the bank
  for (genvar b = 0; b < WORDS; b++) begin : g_bank
    refill_bank #(
      .DATA_W(DATA_W), .ROWS(MEM_LINES), .WORDS(WORDS), .BANK_ID(b)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .row_sel(line_q),
      .rd_data(bank_rd[b])
    );
  end

  assign busy       = t_busy;
  assign word_valid = t_strobe;
  assign word_idx   = t_idx;
  assign word_data  = bank_rd[t_idx];
  assign penalty    = pen_q;

  AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (t_busy && miss_req) |=> $stable(line_q)); // R9

  AST_PENALTY_FORMULA: assert property (@(posedge clk) disable iff (!rst_n)
    t_last |=> (32'(pen_q) == 2 + FRESH + (WORDS - 1) *
      ((t_org == ORG_PAGE) ? COL : (t_org == ORG_BANK) ? 1 : FRESH))); // R8

  AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> busy); // R2

endmodule

// File: tb/refill_line_ctrl_test.sv
module refill_line_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 4;
  localparam int IDX_W  = 2;
  localparam int CNT_W  = 7;
  localparam int CNT1_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_req = 1'b0;
  logic [LINE_W-1:0] miss_line = '0;
  logic [1:0] org = 2'd0;
  logic busy, word_valid;
  logic [IDX_W-1:0] word_idx;
  logic [31:0] word_data;
  logic [CNT_W-1:0] penalty;

  logic s_req = 1'b0;
  logic s_busy, s_valid;
  logic [0:0] s_idx;
  logic [31:0] s_data;
  logic [CNT1_W-1:0] s_pen;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refill_line_ctrl uut (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_line(miss_line),
    .org(org), .busy(busy), .word_valid(word_valid), .word_idx(word_idx),
    .word_data(word_data), .penalty(penalty));

  refill_line_ctrl #(.WORDS(1)) uut_single (
    .clk(clk), .rst_n(rst_n), .miss_req(s_req), .miss_line(miss_line),
    .org(2'd0), .busy(s_busy), .word_valid(s_valid), .word_idx(s_idx),
    .word_data(s_data), .penalty(s_pen));

  // vectors: {org, line, expected penalty}
  localparam int NVEC = 7;
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 4'd3,  10'd102},
    {2'd1, 4'd5,  10'd51},
    {2'd2, 4'd9,  10'd30},
    {2'd3, 4'd0,  10'd102},
    {2'd2, 4'd15, 10'd30},
    {2'd1, 4'd0,  10'd51},
    {2'd0, 4'd12, 10'd102}
  };

  function automatic logic [31:0] expect_word(int a);
    logic [15:0] hi, lo;
    hi = 16'hCA00 + 16'(a);
    lo = 16'(a) ^ 16'h0F0F;
    return {hi, lo};
  endfunction

  function automatic int gap_of(logic [1:0] m);
    if (m == 2'd1) return 8;
    if (m == 2'd2) return 1;
    return 25;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one refill; mid_org/mid_req inject changes during the refill
  task automatic refill(logic [1:0] m, logic [3:0] ln, int exp_pen,
                        bit disturb);
    int c;
    int n;
    @(negedge clk);
    miss_req = 1'b1; org = m; miss_line = ln;
    @(negedge clk);
    miss_req = 1'b0;
    c = 2;
    n = 0;
    check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    while (n < 4 && c < 300) begin
      if (disturb && c == 5) begin
        org = m ^ 2'd1; miss_req = 1'b1; miss_line = ln ^ 4'd7;
      end
      if (disturb && c == 6) miss_req = 1'b0;
      if (word_valid) begin
        check(int'(word_idx) == n, "R3 word order", int'(word_idx), n);
        check(word_data == expect_word(int'(ln) * 4 + n), "R3 word data",
              int'(word_data), int'(expect_word(int'(ln) * 4 + n)));
        check(c == 27 + n * gap_of(m), "R4 R5 R6 strobe cycle", c,
              27 + n * gap_of(m));
        n++;
      end else begin
        check(busy == 1'b1, "R2 busy held", int'(busy), 1);
      end
      if (n < 4) begin
        @(negedge clk);
        c++;
      end
    end
    check(n == 4, "R3 word count", n, 4);
    @(negedge clk);
    check(busy == 1'b0, "R2 idle after last", int'(busy), 0);
    check(int'(penalty) == exp_pen, "R8 penalty", int'(penalty), exp_pen);
    org = 2'd0;
  endtask

  task automatic run_all();
    int c;
    int pen_keep;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    check(word_valid == 1'b0, "R1 valid reset", int'(word_valid), 0);
    check(penalty == '0, "R1 penalty reset", int'(penalty), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      refill(VEC[i][15:14], VEC[i][13:10], int'(VEC[i][9:0]), 1'b0);

    // R9 R10: request and org change during a refill are ignored
    refill(2'd2, 4'd2, 30, 1'b1);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R9 no extra refill", int'(busy), 0);
    check(int'(penalty) == 30, "R9 penalty unchanged", int'(penalty), 30);
    refill(2'd1, 4'd6, 51, 1'b1);
    refill(2'd0, 4'd11, 102, 1'b1);

    // R8 penalty holds while idle
    pen_keep = int'(penalty);
    repeat (10) @(negedge clk);
    check(int'(penalty) == pen_keep, "R8 penalty hold", int'(penalty),
          pen_keep);

    // R7 single-word line
    @(negedge clk);
    s_req = 1'b1; miss_line = 4'd13;
    @(negedge clk);
    s_req = 1'b0;
    c = 2;
    while (!s_valid && c < 100) begin
      @(negedge clk);
      c++;
    end
    check(c == 27, "R7 single strobe cycle", c, 27);
    check(s_data == expect_word(13), "R7 single data", int'(s_data),
          int'(expect_word(13)));
    @(negedge clk);
    check(s_busy == 1'b0, "R7 single idle", int'(s_busy), 0);
    check(int'(s_pen) == 27, "R7 single penalty", int'(s_pen), 27);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule